// File: doc/BRIEF.md
# Task File Register Select Decoder

This block turns a host bus cycle on a removable storage card into a single register select for the card's ATA task file. The host sees the task file through one of several address layouts. A two-bit configuration index picks one of four layouts: a 2 Kbyte window in common memory, a compact sixteen-byte I/O block, or one of two fixed legacy I/O ranges. A strap input overrides the index and puts the card in a disk-style mode, where the two card enables choose between the command block and the control block.

For every qualified read or write the decoder raises at most one of twelve select lines and reports which byte lanes of the 16-bit data bus carry the transfer. A cycle that hits no register raises nothing. The outputs are registered and appear one clock after the inputs are sampled. The registers themselves and command handling sit in neighbouring logic that consumes these selects.

Top module: `task_file_decoder`

## Requirements
- R1: Outputs `reg_sel` and `byte_lane` are registered and reflect the inputs sampled one rising edge earlier. While `rst_n` is low both are zero.
- R2: `reg_sel` is zero or one-hot. Bit positions: 0 data, 1 error/feature, 2 sector count, 3 sector number, 4 cylinder low, 5 cylinder high, 6 drive/head, 7 status, 8 command, 9 alternate status, 10 device control, 11 drive address. When both strobes are high or both are low, `reg_sel` and `byte_lane` are zero. `byte_lane` is zero whenever `reg_sel` is zero.
- R3: With index 1 (compact I/O) only address bits 3..0 count. Offsets 0..6 select bits 0..6 in order. Offset 7 selects status on a read and command on a write.
- R4: With index 1, offsets 8H and 9H select data (even and odd byte) and offset DH selects error/feature. Offset EH selects alternate status on a read and device control on a write. Offset FH selects drive address. Offsets AH..CH select nothing, and address bits 10..4 have no effect.
- R5: With index 2, address bits 9..0 must equal 1F0H..1F7H (offset order as in R3) or 3F6H/3F7H (alternate status or device control, then drive address). Bit 10 is ignored and any other address selects nothing.
- R6: With index 3 the same decode applies at 170H..177H and 376H/377H.
- R7: With index 0 and `space_sel` high, an address with bit 10 set selects data for every offset. With bit 10 clear, the low nibble decodes as in R3/R4.
- R8: With index 0 and `space_sel` low (attribute space), nothing is selected.
- R9: With `disk_strap` high the index is ignored and only address bits 2..0 count. `en_lo_n` low alone selects the eight command-block registers. `en_hi_n` low alone selects alternate status/device control at 6 and drive address at 7, and nothing elsewhere. Both enables low, or both high, selects nothing. Lanes are `01`, or `11` when data is selected.
- R10: Outside the strap mode, lanes (`byte_lane[0]` even, `[1]` odd) follow the enables. Both low is a word access with A0 taken as 0 and lanes `11`. `en_lo_n` low alone is a byte access at A0, giving lanes `01` or `10`. `en_hi_n` low alone is an odd-byte access with A0 taken as 1 and lanes `10`.
- R11: A word access at an even data offset selects data with both lanes set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| host_addr | input | ADDR_W | Host address bus, bit 0 is A0 |
| en_lo_n | input | 1 | Low-byte card enable, active low |
| en_hi_n | input | 1 | High-byte card enable, active low |
| space_sel | input | 1 | 1 = common memory, 0 = attribute memory |
| rd_strb_n | input | 1 | Read strobe, active low |
| wr_strb_n | input | 1 | Write strobe, active low |
| map_index | input | 2 | Layout index: 0 memory, 1 compact I/O, 2 primary I/O, 3 secondary I/O |
| disk_strap | input | 1 | Disk-style mode strap, overrides `map_index` |
| reg_sel | output | 12 | One-hot register select |
| byte_lane | output | 2 | Active byte lanes: bit 0 even, bit 1 odd |

## Verification
The bench builds the decoder with its default parameters. These are an 11-bit address, the registered output variant, and the standard legacy bases 1F0H/3F6H and 170H/376H. With 11 address bits the bench can reach the FIFO half of the memory window, set A10 in the I/O layouts to show it is ignored, and set upper bits in the compact layout. Because the output is registered, a scoreboard that expects each result one edge after its stimulus also exposes any change in latency.

// File: rtl/tfd_pkg.sv
package tfd_pkg;

   localparam int NSEL       = 12;
   localparam int SEL_DATA   = 0;
   localparam int SEL_ERRF   = 1;
   localparam int SEL_STATUS = 7;
   localparam int SEL_CMD    = 8;
   localparam int SEL_ALT    = 9;
   localparam int SEL_DEVC   = 10;
   localparam int SEL_DRVA   = 11;

   typedef enum logic [1:0] {
      MAP_MEM    = 2'd0,
      MAP_CONTIG = 2'd1,
      MAP_PRI    = 2'd2,
      MAP_SEC    = 2'd3
   } map_e;

   typedef enum logic [2:0] {
      SL_NONE = 3'd0,
      SL_TF   = 3'd1,
      SL_DATA = 3'd2,
      SL_ERRF = 3'd3,
      SL_CTL  = 3'd4
   } slot_e;

   typedef struct packed {
      slot_e      kind;
      logic [2:0] off;
   } hit_t;

   // sixteen-byte block decode shared by the compact layout and the low memory window
   function automatic hit_t nibble_hit(input logic [3:0] n);
      hit_t h;
      h.kind = SL_NONE;
      h.off  = 3'd0;
      if (!n[3]) begin
         h.kind = SL_TF;
         h.off  = n[2:0];
      end else begin
         case (n[2:0])
            3'd0, 3'd1: h.kind = SL_DATA;
            3'd5:       h.kind = SL_ERRF;
            3'd6:       begin h.kind = SL_CTL; h.off = 3'd0; end
            3'd7:       begin h.kind = SL_CTL; h.off = 3'd1; end
            default:    h.kind = SL_NONE;
         endcase
      end
      return h;
   endfunction

endpackage

// File: rtl/tfd_lane.sv
module tfd_lane (
   input  logic       en_lo_n,
   input  logic       en_hi_n,
   input  logic       a0,
   output logic       ok,
   output logic       a0_eff,
   output logic [1:0] lane
);

   always_comb begin
      ok     = 1'b0;
      a0_eff = a0;
      lane   = 2'b00;
      case ({en_hi_n, en_lo_n})
         2'b00: begin            // word
            ok     = 1'b1;
            a0_eff = 1'b0;
            lane   = 2'b11;
         end
         2'b10: begin            // low enable only: byte at A0
            ok     = 1'b1;
            a0_eff = a0;
            lane   = a0 ? 2'b10 : 2'b01;
         end
         2'b01: begin            // high enable only: odd byte
            ok     = 1'b1;
            a0_eff = 1'b1;
            lane   = 2'b10;
         end
         default: ok = 1'b0;
      endcase
   end

   // R10: a usable cycle always names at least one lane
   always_comb begin
      if (ok) assert (lane != 2'b00) else $error("lane_r10 empty lane on valid cycle");
   end

endmodule

// File: rtl/tfd_io_window.sv
module tfd_io_window
   import tfd_pkg::*;
#(
   parameter logic [9:0] TF_BASE  = 10'h1F0,
   parameter logic [9:0] CTL_BASE = 10'h3F6
) (
   input  logic [9:0] addr,
   output hit_t       hit
);

   if (TF_BASE[2:0] != 3'd0) begin : g_bad_tf
      $error("TF_BASE must be eight-byte aligned");
   end
   if (CTL_BASE[0] != 1'b0) begin : g_bad_ctl
      $error("CTL_BASE must be even");
   end

   always_comb begin
      hit.kind = SL_NONE;
      hit.off  = 3'd0;
      if (addr[9:3] == TF_BASE[9:3]) begin
         hit.kind = SL_TF;
         hit.off  = addr[2:0];
      end else if (addr[9:1] == CTL_BASE[9:1]) begin
         hit.kind = SL_CTL;
         hit.off  = {2'b00, addr[0]};
      end
   end

endmodule

// File: rtl/tfd_slot_map.sv
module tfd_slot_map
   import tfd_pkg::*;
(
   input  hit_t            hit,
   input  logic            is_rd,
   output logic [NSEL-1:0] sel
);

   always_comb begin
      sel = '0;
      case (hit.kind)
         SL_TF: begin
            if (hit.off == 3'd7) sel[is_rd ? SEL_STATUS : SEL_CMD] = 1'b1;
            else                 sel[hit.off] = 1'b1;
         end
         SL_DATA: sel[SEL_DATA] = 1'b1;
         SL_ERRF: sel[SEL_ERRF] = 1'b1;
         SL_CTL: begin
            if (hit.off[0]) sel[SEL_DRVA] = 1'b1;
            else            sel[is_rd ? SEL_ALT : SEL_DEVC] = 1'b1;
         end
         default: sel = '0;
      endcase
   end

   // R2: a single slot never lights two lines
   always_comb begin
      assert ($onehot0(sel)) else $error("map_r2 multiple selects");
   end

endmodule

// File: rtl/task_file_decoder.sv
module task_file_decoder
   import tfd_pkg::*;
#(
   parameter int         ADDR_W       = 11,
   parameter bit         REG_OUT      = 1'b1,
   parameter logic [9:0] PRI_TF_BASE  = 10'h1F0,
   parameter logic [9:0] PRI_CTL_BASE = 10'h3F6,
   parameter logic [9:0] SEC_TF_BASE  = 10'h170,
   parameter logic [9:0] SEC_CTL_BASE = 10'h376
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] host_addr,
   input  logic              en_lo_n,
   input  logic              en_hi_n,
   input  logic              space_sel,
   input  logic              rd_strb_n,
   input  logic              wr_strb_n,
   input  logic [1:0]        map_index,
   input  logic              disk_strap,
   output logic [NSEL-1:0]   reg_sel,
   output logic [1:0]        byte_lane
);

   localparam int WIN_BIT = 10;   // memory window FIFO half
   localparam int NWIN    = 2;
   localparam logic [9:0] TF_B  [NWIN] = '{PRI_TF_BASE, SEC_TF_BASE};
   localparam logic [9:0] CTL_B [NWIN] = '{PRI_CTL_BASE, SEC_CTL_BASE};

   if (ADDR_W < 11) begin : g_bad_aw
      $error("ADDR_W must cover the 2 Kbyte window");
   end

   logic acc_rd, acc_wr, acc;
   assign acc_rd = !rd_strb_n &&  wr_strb_n;
   assign acc_wr =  rd_strb_n && !wr_strb_n;
   assign acc    = acc_rd || acc_wr;

   logic       pc_ok, a0_eff;
   logic [1:0] pc_lane;

   tfd_lane u_lane (
      .en_lo_n (en_lo_n),
      .en_hi_n (en_hi_n),
      .a0      (host_addr[0]),
      .ok      (pc_ok),
      .a0_eff  (a0_eff),
      .lane    (pc_lane)
   );

   logic [ADDR_W-1:0] pc_addr;
   assign pc_addr = {host_addr[ADDR_W-1:1], a0_eff};

   hit_t win_hit [NWIN];

   for (genvar g = 0; g < NWIN; g++) begin : g_win
      tfd_io_window #(
         .TF_BASE  (TF_B[g]),
         .CTL_BASE (CTL_B[g])
      ) u_win (
         .addr (pc_addr[9:0]),
         .hit  (win_hit[g])
      );
   end

   hit_t       hit_c;
   logic [1:0] lane_c;

   always_comb begin
      hit_c.kind = SL_NONE;
      hit_c.off  = 3'd0;
      lane_c     = 2'b00;
      if (acc) begin
         if (disk_strap) begin
            if (!en_lo_n && en_hi_n) begin
               hit_c.kind = SL_TF;
               hit_c.off  = host_addr[2:0];
            end else if (en_lo_n && !en_hi_n && host_addr[2:1] == 2'b11) begin
               hit_c.kind = SL_CTL;
               hit_c.off  = {2'b00, host_addr[0]};
            end
         end else if (pc_ok) begin
            case (map_e'(map_index))
               MAP_MEM: begin
                  if (space_sel) begin
                     if (pc_addr[WIN_BIT]) begin
                        hit_c.kind = SL_DATA;
                     end else begin
                        hit_c = nibble_hit(pc_addr[3:0]);
                     end
                  end
               end
               MAP_CONTIG: hit_c = nibble_hit(pc_addr[3:0]);
               MAP_PRI:    hit_c = win_hit[0];
               MAP_SEC:    hit_c = win_hit[1];
               default:    hit_c.kind = SL_NONE;
            endcase
         end
      end
      if (hit_c.kind != SL_NONE) begin
         if (disk_strap)
            lane_c = {(hit_c.kind == SL_TF && hit_c.off == 3'd0), 1'b1};
         else
            lane_c = pc_lane;
      end
   end

   logic [NSEL-1:0] sel_c;

   tfd_slot_map u_map (
      .hit   (hit_c),
      .is_rd (acc_rd),
      .sel   (sel_c)
   );

   if (REG_OUT) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            reg_sel   <= '0;
            byte_lane <= 2'b00;
         end else begin
            reg_sel   <= sel_c;
            byte_lane <= lane_c;
         end
      end

      p_onehot_r2: assert property (@(posedge clk) disable iff (!rst_n)
         $onehot0(reg_sel));

      p_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
         (rd_strb_n == wr_strb_n) |=> (reg_sel == '0 && byte_lane == 2'b00));

      p_lane_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
         (reg_sel == '0) |-> (byte_lane == 2'b00));

      p_cmd_dir_r3: assert property (@(posedge clk) disable iff (!rst_n)
         reg_sel[SEL_CMD] |-> $past(!wr_strb_n));

      p_status_dir_r3: assert property (@(posedge clk) disable iff (!rst_n)
         reg_sel[SEL_STATUS] |-> $past(!rd_strb_n));

      p_fifo_r7: assert property (@(posedge clk) disable iff (!rst_n)
         (!disk_strap && map_index == 2'd0 && space_sel && host_addr[WIN_BIT]
          && (rd_strb_n != wr_strb_n) && !(en_lo_n && en_hi_n))
         |=> (reg_sel == NSEL'(1) << SEL_DATA));

      p_attr_r8: assert property (@(posedge clk) disable iff (!rst_n)
         (!disk_strap && map_index == 2'd0 && !space_sel) |=> (reg_sel == '0));

      p_strap_both_r9: assert property (@(posedge clk) disable iff (!rst_n)
         (disk_strap && !en_lo_n && !en_hi_n) |=> (reg_sel == '0));

      p_word_r10: assert property (@(posedge clk) disable iff (!rst_n)
         (!disk_strap && !en_lo_n && !en_hi_n && (rd_strb_n != wr_strb_n))
         |=> (reg_sel == '0 || byte_lane == 2'b11));
   end else begin : g_comb
      assign reg_sel   = sel_c;
      assign byte_lane = lane_c;
   end

endmodule

// File: tb/task_file_decoder_bench.sv
`timescale 1ns/1ps
module task_file_decoder_bench;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [10:0] host_addr = '0;
   logic        en_lo_n = 1'b1, en_hi_n = 1'b1, space_sel = 1'b1;
   logic        rd_strb_n = 1'b1, wr_strb_n = 1'b1;
   logic [1:0]  map_index = 2'd1;
   logic        disk_strap = 1'b0;
   logic [11:0] reg_sel;
   logic [1:0]  byte_lane;

   always #4 clk = ~clk;   // 125 MHz

   task_file_decoder u_task_file_decoder (
      .clk(clk), .rst_n(rst_n), .host_addr(host_addr),
      .en_lo_n(en_lo_n), .en_hi_n(en_hi_n), .space_sel(space_sel),
      .rd_strb_n(rd_strb_n), .wr_strb_n(wr_strb_n),
      .map_index(map_index), .disk_strap(disk_strap),
      .reg_sel(reg_sel), .byte_lane(byte_lane)
   );

   localparam logic [11:0] M_DATA = 12'h001, M_ERRF = 12'h002, M_SCNT = 12'h004,
                           M_CLO  = 12'h010, M_CHI  = 12'h020, M_DRH  = 12'h040,
                           M_STAT = 12'h080, M_CMD  = 12'h100, M_ALT  = 12'h200,
                           M_DEVC = 12'h400, M_DRVA = 12'h800, M_NONE = 12'h000;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   logic [13:0] exp_q [$];
   string       tag_q [$];

   task automatic go(input logic [1:0] idx, input logic strap, input logic sp,
                     input logic [10:0] a, input logic lo_n, input logic hi_n,
                     input logic rdn, input logic wrn,
                     input logic [11:0] es, input logic [1:0] el, input string tag);
      @(negedge clk);
      map_index = idx; disk_strap = strap; space_sel = sp; host_addr = a;
      en_lo_n = lo_n; en_hi_n = hi_n; rd_strb_n = rdn; wr_strb_n = wrn;
      exp_q.push_back({es, el});
      tag_q.push_back(tag);
   endtask

   // monitor: each expectation is due one rising edge after it was driven (R1)
   initial begin
      forever begin
         @(posedge clk);
         #2;
         if (exp_q.size() > 0) begin
            logic [13:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            checks++;
            if ({reg_sel, byte_lane} !== e) begin
               errors++;
               $display("FAIL %s: sel=%h lane=%b expected sel=%h lane=%b",
                        t, reg_sel, byte_lane, e[13:2], e[1:0]);
            end
         end
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL R1 watchdog: actual hung expected finish");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      // R1: reset holds outputs at zero even with a live access on the pins
      map_index = 2'd1; host_addr = 11'h007; en_lo_n = 1'b0; rd_strb_n = 1'b0;
      repeat (3) @(posedge clk);
      #2;
      checks++;
      if (reg_sel !== 12'h0 || byte_lane !== 2'b00) begin
         errors++;
         $display("FAIL R1 reset: sel=%h lane=%b expected sel=000 lane=00", reg_sel, byte_lane);
      end
      @(negedge clk);
      rst_n = 1'b1;
      en_lo_n = 1'b1; rd_strb_n = 1'b1;

      // R3 compact layout, byte reads through the low enable
      for (int k = 0; k < 8; k++)
         go(2'd1, 0, 1, 11'(k), 0, 1, 0, 1,
            (k == 7) ? M_STAT : (12'h001 << k), k[0] ? 2'b10 : 2'b01, "R3 compact read");
      go(2'd1, 0, 1, 11'h007, 0, 1, 1, 0, M_CMD, 2'b10, "R3 compact write 7");

      // R4 duplicates and holes
      go(2'd1, 0, 1, 11'h008, 0, 1, 0, 1, M_DATA, 2'b01, "R4 dup even data");
      go(2'd1, 0, 1, 11'h009, 0, 1, 0, 1, M_DATA, 2'b10, "R4 dup odd data");
      go(2'd1, 0, 1, 11'h00D, 0, 1, 0, 1, M_ERRF, 2'b10, "R4 dup err");
      go(2'd1, 0, 1, 11'h00E, 0, 1, 0, 1, M_ALT,  2'b01, "R4 alt read");
      go(2'd1, 0, 1, 11'h00E, 0, 1, 1, 0, M_DEVC, 2'b01, "R4 devctl write");
      go(2'd1, 0, 1, 11'h00F, 0, 1, 0, 1, M_DRVA, 2'b10, "R4 drive addr");
      go(2'd1, 0, 1, 11'h00B, 0, 1, 0, 1, M_NONE, 2'b00, "R4 hole B");
      go(2'd1, 0, 1, 11'h7F5, 0, 1, 0, 1, M_CHI,  2'b10, "R4 upper bits ignored");

      // R5 primary
      go(2'd2, 0, 1, 11'h1F0, 0, 0, 0, 1, M_DATA, 2'b11, "R5 R11 word data");
      go(2'd2, 0, 1, 11'h1F7, 0, 1, 1, 0, M_CMD,  2'b10, "R5 command");
      go(2'd2, 0, 1, 11'h3F6, 0, 1, 0, 1, M_ALT,  2'b01, "R5 alt status");
      go(2'd2, 0, 1, 11'h3F7, 0, 1, 0, 1, M_DRVA, 2'b10, "R5 drive addr");
      go(2'd2, 0, 1, 11'h5F2, 0, 1, 0, 1, M_SCNT, 2'b01, "R5 A10 ignored");
      go(2'd2, 0, 1, 11'h1F8, 0, 1, 0, 1, M_NONE, 2'b00, "R5 outside");
      go(2'd2, 0, 1, 11'h170, 0, 1, 0, 1, M_NONE, 2'b00, "R5 secondary address miss");

      // R6 secondary
      go(2'd3, 0, 1, 11'h172, 0, 1, 0, 1, M_SCNT, 2'b01, "R6 sector count");
      go(2'd3, 0, 1, 11'h377, 0, 1, 0, 1, M_DRVA, 2'b10, "R6 drive addr");
      go(2'd3, 0, 1, 11'h1F0, 0, 1, 0, 1, M_NONE, 2'b00, "R6 primary address miss");

      // R7 R8 memory window
      go(2'd0, 0, 1, 11'h004, 0, 1, 0, 1, M_CLO,  2'b01, "R7 low window");
      go(2'd0, 0, 1, 11'h400, 0, 1, 0, 1, M_DATA, 2'b01, "R7 fifo start");
      go(2'd0, 0, 1, 11'h7FF, 0, 1, 0, 1, M_DATA, 2'b10, "R7 fifo end");
      go(2'd0, 0, 1, 11'h5A2, 0, 0, 0, 1, M_DATA, 2'b11, "R7 R11 fifo word");
      go(2'd0, 0, 0, 11'h000, 0, 1, 0, 1, M_NONE, 2'b00, "R8 attribute space");
      go(2'd0, 0, 0, 11'h400, 0, 0, 0, 1, M_NONE, 2'b00, "R8 attribute fifo");

      // R10 lane rules
      go(2'd0, 0, 1, 11'h000, 1, 0, 0, 1, M_ERRF, 2'b10, "R10 odd enable A0 forced");
      go(2'd0, 0, 1, 11'h003, 0, 0, 0, 1, M_SCNT, 2'b11, "R10 word A0 cleared");
      go(2'd1, 0, 1, 11'h008, 1, 0, 0, 1, M_DATA, 2'b10, "R10 odd enable dup data");

      // R9 strap mode (index ignored)
      go(2'd1, 1, 0, 11'h007, 0, 1, 0, 1, M_STAT, 2'b01, "R9 status");
      go(2'd1, 1, 0, 11'h007, 0, 1, 1, 0, M_CMD,  2'b01, "R9 command");
      go(2'd2, 1, 0, 11'h000, 0, 1, 0, 1, M_DATA, 2'b11, "R9 data lanes");
      go(2'd0, 1, 0, 11'h00E, 0, 1, 0, 1, M_DRH,  2'b01, "R9 only A2..A0");
      go(2'd3, 1, 0, 11'h006, 1, 0, 0, 1, M_ALT,  2'b01, "R9 alt read");
      go(2'd3, 1, 0, 11'h006, 1, 0, 1, 0, M_DEVC, 2'b01, "R9 devctl write");
      go(2'd1, 1, 0, 11'h007, 1, 0, 0, 1, M_DRVA, 2'b01, "R9 drive addr");
      go(2'd1, 1, 0, 11'h005, 1, 0, 0, 1, M_NONE, 2'b00, "R9 control hole");
      go(2'd1, 1, 0, 11'h001, 0, 0, 0, 1, M_NONE, 2'b00, "R9 both enables");

      // R2 strobe qualification
      go(2'd1, 0, 1, 11'h002, 0, 1, 1, 1, M_NONE, 2'b00, "R2 no strobe");
      go(2'd1, 0, 1, 11'h002, 0, 1, 0, 0, M_NONE, 2'b00, "R2 both strobes");
      go(2'd1, 0, 1, 11'h002, 1, 1, 0, 1, M_NONE, 2'b00, "R2 no enable");
      go(2'd1, 0, 1, 11'h002, 0, 1, 0, 1, M_SCNT, 2'b01, "R1 back to back");

      @(negedge clk);
      rd_strb_n = 1'b1; wr_strb_n = 1'b1;
      repeat (4) @(posedge clk);
      #3;
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule